// File: doc/BRIEF.md
# Grouped Interrupt Summary Aggregator

This block gathers the per-pin event flags of a large GPIO array and folds them into a compact summary. Every pin offers two flags, an interrupt flag and a wake flag, and a pin counts as pending while either one is high. The pins are taken in runs of four consecutive pins. Each run sets one summary bit, so with the default 184 pins the summary has 46 meaningful bits. The summary is registered once. Software reads it as two 32-bit words: the low word holds summary bits 31..0, and the high word holds the remaining bits packed from bit 0 upward, with zeros above them.

A single interrupt line goes to the host. The line is armed out of reset. When it is armed and any summary bit is set, the line goes high for exactly one cycle and then disarms. Further events do not raise it again until software writes a master control word with the end-of-interrupt bit set. That write re-arms the line. If events are still pending at that moment, the line fires on the cycle right after the write. The end-of-interrupt bit is never stored. The other bits of the master word are kept and read back.

The per-pin detection and clearing logic, and the bus that carries the reads and writes, sit outside this block.

Top module: `gsum_aggregator`

## Requirements
- R1: Summary bit n is the OR of the pending flags of pins 4n, 4n+1, 4n+2 and 4n+3. It is registered, so it reflects the pin flags one clock edge after they change.
- R2: A pin is pending when its interrupt flag is high, when its wake flag is high, or when both are high.
- R3: With rd_sel = 0, rd_data returns summary bits 31..0 at bit positions 31..0.
- R4: With rd_sel = 1, rd_data returns summary bits 45..32 at bit positions 13..0, and bits 31..14 read as zero.
- R5: When the line is armed and at least one summary bit is set, irq_out is high for exactly one cycle, and the line then disarms.
- R6: While the line is disarmed and no end-of-interrupt is written, irq_out stays low even if new pin events arrive.
- R7: A master write with bit 29 set, made while a summary bit is pending, makes irq_out high in the cycle that follows the write edge.
- R8: An end-of-interrupt written while nothing is pending leaves irq_out low, and the next pin event then raises irq_out one edge after it appears.
- R9: With rd_sel = 2, rd_data returns the last master word written, with bit 29 (the end-of-interrupt bit) always reading 0.
- R10: After reset the summary is zero, the stored master word is zero, irq_out is low and the line is armed.
- R11: With rd_sel = 3, rd_data reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_sts | input | 184 | Per-pin interrupt-pending flags |
| wake_sts | input | 184 | Per-pin wake-pending flags |
| mstr_wr | input | 1 | Write strobe for the master control word |
| mstr_wdata | input | 32 | Master control word; bit 29 is end-of-interrupt |
| rd_sel | input | 2 | Read select: 0 low summary, 1 high summary, 2 master, 3 none |
| rd_data | output | 32 | Read data for the selected word |
| irq_out | output | 1 | Shared interrupt line to the host |

## Verification
The grouping is exercised by setting one pin at a time. The chosen pins are the first and last pin of a group, and the pins on either side of the boundary between the low and high words. Some are set through the interrupt flag and some through the wake flag. Each read of the word being tested is paired with a read of the opposite word, and that read must be zero, so a wrong group index, a wrong word split or an ignored flag all show up. A full group of four pins is also set together, and the summary is sampled both before and after the register edge. The interrupt line is then taken through firing, holding low while new events arrive, re-arming with events pending and re-arming with nothing pending. This tells a missing disarm apart from a missing re-arm.

// File: rtl/gsum_pkg.sv
package gsum_pkg;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_MSTR = 2'd2,
    SEL_NONE = 2'd3
  } rdsel_e;

  // number of summary groups for a pin count and group size
  function automatic int unsigned grp_count(input int unsigned pins,
                                            input int unsigned per);
    return pins / per;
  endfunction

  // summary bits that spill into the high read word
  function automatic int unsigned hi_bits(input int unsigned ngrp,
                                          input int unsigned word);
    return (ngrp > word) ? (ngrp - word) : 0;
  endfunction

endpackage

// File: rtl/gsum_grouper.sv
module gsum_grouper #(
  parameter int unsigned NPINS = 184,
  parameter int unsigned PPG   = 4,
  parameter int unsigned NGRP  = NPINS / PPG
) (
  input  logic [NPINS-1:0] int_sts,
  input  logic [NPINS-1:0] wake_sts,
  output logic [NGRP-1:0]  grp_d
);
  logic [NPINS-1:0] pend;

  assign pend = int_sts | wake_sts;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_d[g] = |pend[g*PPG +: PPG];
  end
endmodule

// File: rtl/gsum_arm_ctrl.sv
module gsum_arm_ctrl #(
  parameter int unsigned WORD    = 32,
  parameter int unsigned EOI_BIT = 29
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mstr_wr,
  input  logic [WORD-1:0] mstr_wdata,
  input  logic            sum_any,
  output logic            irq_out,
  output logic            armed,
  output logic            eoi_hit,
  output logic [WORD-1:0] mstr_q
);
  logic fire;

  assign eoi_hit = mstr_wr & mstr_wdata[EOI_BIT];
  assign fire    = armed & sum_any;
  assign irq_out = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
    end else if (eoi_hit) begin
      armed <= 1'b1;
    end else if (fire) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstr_q <= '0;
    end else if (mstr_wr) begin
      mstr_q <= mstr_wdata & ~(WORD'(1) << EOI_BIT);
    end
  end
endmodule

// File: rtl/gsum_readback.sv
module gsum_readback
  import gsum_pkg::*;
#(
  parameter int unsigned NGRP = 46,
  parameter int unsigned WORD = 32
) (
  input  rdsel_e          sel,
  input  logic [NGRP-1:0] sum_q,
  input  logic [WORD-1:0] mstr_q,
  output logic [WORD-1:0] rd_data
);
  localparam int unsigned HIB = hi_bits(NGRP, WORD);

  logic [WORD-1:0] lo_w;
  logic [WORD-1:0] hi_w;

  if (HIB > 0) begin : g_split
    assign lo_w = sum_q[WORD-1:0];
    assign hi_w = {{(WORD-HIB){1'b0}}, sum_q[NGRP-1:WORD]};
  end else begin : g_single
    assign lo_w = WORD'(sum_q);
    assign hi_w = '0;
  end

  always_comb begin
    unique case (sel)
      SEL_LO:   rd_data = lo_w;
      SEL_HI:   rd_data = hi_w;
      SEL_MSTR: rd_data = mstr_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gsum_aggregator.sv
module gsum_aggregator
  import gsum_pkg::*;
#(
  parameter int unsigned NPINS   = 184,
  parameter int unsigned PPG     = 4,
  parameter int unsigned WORD    = 32,
  parameter int unsigned EOI_BIT = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] int_sts,
  input  logic [NPINS-1:0] wake_sts,
  input  logic             mstr_wr,
  input  logic [WORD-1:0]  mstr_wdata,
  input  logic [1:0]       rd_sel,
  output logic [WORD-1:0]  rd_data,
  output logic             irq_out
);
  localparam int unsigned NGRP = grp_count(NPINS, PPG);

  logic [NGRP-1:0] grp_d;
  logic [NGRP-1:0] sum_q;
  logic            grp_any_d;
  logic            sum_any;
  logic            armed;
  logic            eoi_hit;
  logic [WORD-1:0] mstr_q;

  gsum_grouper #(.NPINS(NPINS), .PPG(PPG), .NGRP(NGRP)) u_grp (
    .int_sts  (int_sts),
    .wake_sts (wake_sts),
    .grp_d    (grp_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= grp_d;
  end

  assign grp_any_d = |grp_d;
  assign sum_any   = |sum_q;

  gsum_arm_ctrl #(.WORD(WORD), .EOI_BIT(EOI_BIT)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mstr_wr    (mstr_wr),
    .mstr_wdata (mstr_wdata),
    .sum_any    (sum_any),
    .irq_out    (irq_out),
    .armed      (armed),
    .eoi_hit    (eoi_hit),
    .mstr_q     (mstr_q)
  );

  gsum_readback #(.NGRP(NGRP), .WORD(WORD)) u_rb (
    .sel     (rdsel_e'(rd_sel)),
    .sum_q   (sum_q),
    .mstr_q  (mstr_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/gsum_aggregator_chk.sv
module gsum_aggregator_chk #(
  parameter int unsigned NGRP    = 46,
  parameter int unsigned WORD    = 32,
  parameter int unsigned EOI_BIT = 29
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_out,
  input logic            armed,
  input logic            eoi_hit,
  input logic            grp_any_d,
  input logic [1:0]      rd_sel,
  input logic [WORD-1:0] rd_data
);
  localparam int unsigned HIB = (NGRP > WORD) ? (NGRP - WORD) : 0;

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !eoi_hit) |=> !irq_out);

  assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !eoi_hit) |=> !irq_out);

  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && grp_any_d) |=> irq_out);

  assert_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd1) |-> (rd_data >> HIB) == '0);

  assert_eoi_reads0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd2) |-> !rd_data[EOI_BIT]);

  assert_none_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd3) |-> rd_data == '0);
endmodule

bind gsum_aggregator gsum_aggregator_chk #(
  .NGRP(NGRP), .WORD(WORD), .EOI_BIT(EOI_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_out   (irq_out),
  .armed     (armed),
  .eoi_hit   (eoi_hit),
  .grp_any_d (grp_any_d),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data)
);

// File: tb/sim_gsum_aggregator.sv
module sim_gsum_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 184;
  localparam int W  = 32;
  localparam logic [W-1:0] EOI = 32'h2000_0000;

  // {pin, use_wake, word_sel, expected word}
  localparam logic [41:0] VEC [10] = '{
    {8'd0,   1'b0, 1'b0, 32'h0000_0001},
    {8'd3,   1'b1, 1'b0, 32'h0000_0001},
    {8'd4,   1'b0, 1'b0, 32'h0000_0002},
    {8'd61,  1'b0, 1'b0, 32'h0000_8000},
    {8'd127, 1'b1, 1'b0, 32'h8000_0000},
    {8'd128, 1'b0, 1'b1, 32'h0000_0001},
    {8'd131, 1'b1, 1'b1, 32'h0000_0001},
    {8'd132, 1'b0, 1'b1, 32'h0000_0002},
    {8'd183, 1'b0, 1'b1, 32'h0000_2000},
    {8'd180, 1'b1, 1'b1, 32'h0000_2000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] int_sts = '0;
  logic [NP-1:0] wake_sts = '0;
  logic          mstr_wr = 1'b0;
  logic [W-1:0]  mstr_wdata = '0;
  logic [1:0]    rd_sel = 2'd0;
  logic [W-1:0]  rd_data;
  logic          irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gsum_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .int_sts(int_sts), .wake_sts(wake_sts),
    .mstr_wr(mstr_wr), .mstr_wdata(mstr_wdata), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    tick();
    tick();
    // R10: reset state
    rd(2'd0, v); check("R10 lo after reset", v, '0);
    rd(2'd1, v); check("R10 hi after reset", v, '0);
    rd(2'd2, v); check("R10 master after reset", v, '0);
    check("R10 irq after reset", W'(irq_out), '0);
    rst_n = 1'b1;
    tick();

    // R10/R5: armed out of reset, first event fires
    int_sts[0] = 1'b1;
    tick();
    check("R10 armed fire", W'(irq_out), 32'h1);
    tick();
    check("R5 one cycle pulse", W'(irq_out), '0);
    int_sts = '0;
    tick();

    // R1/R2/R3/R4: table walk, one pin at a time
    for (int i = 0; i < 10; i++) begin
      int_sts = '0;
      wake_sts = '0;
      if (VEC[i][33]) wake_sts[VEC[i][41:34]] = 1'b1;
      else            int_sts[VEC[i][41:34]]  = 1'b1;
      tick();
      rd({1'b0, VEC[i][32]}, v);
      check(VEC[i][32] ? "R4 R1 R2 hi word" : "R3 R1 R2 lo word", v, VEC[i][31:0]);
      rd({1'b0, ~VEC[i][32]}, v);
      check("R1 R3 R4 other word zero", v, '0);
    end
    int_sts = '0;
    wake_sts = '0;
    tick();

    // R1: full group and register latency
    int_sts[11:8] = 4'hF;
    rd(2'd0, v);
    check("R1 before edge", v, '0);
    tick();
    rd(2'd0, v);
    check("R1 full group", v, 32'h4);
    int_sts = '0;
    tick();

    // R8: EOI with nothing pending
    mstr_wr = 1'b1; mstr_wdata = EOI;
    tick();
    mstr_wr = 1'b0; mstr_wdata = '0;
    check("R8 idle eoi", W'(irq_out), '0);
    tick();
    check("R8 still idle", W'(irq_out), '0);
    int_sts[10] = 1'b1;
    tick();
    check("R8 R5 fire on event", W'(irq_out), 32'h1);
    tick();
    check("R5 disarm", W'(irq_out), '0);

    // R6: new events while disarmed
    wake_sts[50] = 1'b1;
    tick();
    check("R6 hold low", W'(irq_out), '0);
    rd(2'd0, v);
    check("R6 R2 summary updates", v, 32'h0000_1004);
    tick();
    check("R6 hold low later", W'(irq_out), '0);

    // R7: EOI with pending
    mstr_wr = 1'b1; mstr_wdata = EOI;
    tick();
    mstr_wr = 1'b0; mstr_wdata = '0;
    check("R7 refire after eoi", W'(irq_out), 32'h1);
    tick();
    check("R7 R5 single pulse", W'(irq_out), '0);
    int_sts = '0;
    wake_sts = '0;
    tick();

    // R9: master readback, EOI bit reads 0
    mstr_wr = 1'b1; mstr_wdata = 32'hFFFF_FFFF;
    tick();
    mstr_wr = 1'b0; mstr_wdata = '0;
    rd(2'd2, v);
    check("R9 master readback", v, 32'hDFFF_FFFF);
    mstr_wr = 1'b1; mstr_wdata = 32'h0000_00A5;
    tick();
    mstr_wr = 1'b0;
    rd(2'd2, v);
    check("R9 master plain", v, 32'h0000_00A5);

    // R11: unused select
    int_sts[0] = 1'b1;
    tick();
    rd(2'd3, v);
    check("R11 sel3 zero", v, '0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule